// File: doc/BRIEF.md
# Virtual Interrupt Aggregator

The aggregator collects single-bit event messages, each tagged with an event number, into a small set of virtual interrupt lines. A mapping table is programmed through a configuration port. Each table entry assigns an event number to one virtual interrupt index and one bit position inside that interrupt's 64-bit pending word. An "up" message sets the mapped pending bit and a "down" message clears it. This lets one block handle both pulse-style sources, which software acknowledges, and level-style sources, which drop their own bit.

Each virtual interrupt has a 4 KiB register window at byte address `index * 0x1000`. The window holds four 64-bit registers:

- An enable set register at offset 0x0.
- An enable clear register at offset 0x8.
- A raw pending register at offset 0x18.
- A masked pending view at offset 0x20.

Software unmasks a bit by writing a one-hot word to the set register and masks it by writing the same word to the clear register. It acknowledges a pulse-style bit by writing a one-hot word to the raw pending register.

Each virtual interrupt output is an active-high level. It is true whenever that interrupt has a bit that is both pending and enabled. A host handler reads the masked view to find out which bits caused the interrupt.

Top module: `vint_aggregator`

## Requirements
- R1: After reset, every enable and pending register reads zero, every `vint_irq` bit is low, and every mapping entry is invalid.
- R2: A write to window offset 0x0 sets each enable bit whose written bit is 1. Enable bits written as 0 keep their value.
- R3: A write to window offset 0x8 clears each enable bit whose written bit is 1. The pending bits are left as they were.
- R4: A valid up message whose event number is mapped sets the mapped bit in the mapped interrupt's raw pending register (offset 0x18). The change is visible from the next clock edge.
- R5: Window offset 0x20 reads the bitwise AND of raw pending and enable. Offsets 0x0 and 0x8 both read the enable register.
- R6: `vint_irq[v]` is high exactly when interrupt v has a bit that is both pending and enabled. It follows a state change with one register stage.
- R7: A write to offset 0x18 clears each pending bit written as 1 and leaves the other pending bits alone.
- R8: A valid down message for a mapped event clears the mapped pending bit.
- R9: A message for an event number with no valid mapping changes no state. A configuration write with `cfg_map`=0 removes the entry for that event number.
- R10: When an up message and a software pending clear hit the same bit in the same cycle, the bit ends up set.
- R11: Any window offset other than 0x0, 0x8, 0x18 and 0x20 reads zero, and writes to it change nothing.
- R12: `req_ready` is always high. A read accepted in cycle n returns its data with `rsp_valid` high in cycle n+1, and the data shows the register values from before cycle n's updates. Writes produce no response.
- R13: Address bits [14:12] select the interrupt window, so interrupt v's registers sit at v*0x1000 plus the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address: window index and offset |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| cfg_valid | input | 1 | Mapping table write strobe |
| cfg_map | input | 1 | 1 = program the entry, 0 = remove it |
| cfg_evt | input | 8 | Event number to configure |
| cfg_vint | input | 3 | Target virtual interrupt index |
| cfg_bit | input | 6 | Target bit position |
| evt_valid | input | 1 | Event message present |
| evt_num | input | 8 | Event number of the message |
| evt_up | input | 1 | 1 = up (set), 0 = down (clear) |
| vint_irq | output | 8 | One active-high level per virtual interrupt |

## Verification
A wrong mapping entry shows up as a pending bit in the wrong window or at the wrong position. It appears in the raw pending read issued right after the event, and it also appears on `vint_irq` one edge after the event once that bit is enabled. A stuck or lost enable bit or pending bit shows on `vint_irq` in the next cycle, and the masked view exposes the mismatch within two cycles of the read request. Ordering faults, such as an acknowledge that beats a simultaneous up message or a down message that goes to an unmapped slot, leave a pending word that differs from the independently tracked model at the very next read of that window.

// File: rtl/vagg_pkg.sv
package vagg_pkg;

  localparam int WIN_LG = 12;

  typedef enum logic [11:0] {
    OFS_EN_SET = 12'h000,
    OFS_EN_CLR = 12'h008,
    OFS_RAW    = 12'h018,
    OFS_MASKED = 12'h020
  } reg_ofs_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_RAW,
    SEL_MASKED
  } rd_sel_e;

  function automatic rd_sel_e decode_read(input logic [WIN_LG-1:0] ofs);
    case (ofs)
      OFS_EN_SET, OFS_EN_CLR: decode_read = SEL_ENABLE;
      OFS_RAW:                decode_read = SEL_RAW;
      OFS_MASKED:             decode_read = SEL_MASKED;
      default:                decode_read = SEL_NONE;
    endcase
  endfunction

  function automatic logic win_selects(input logic [WIN_LG+7:0] win, input int idx,
                                       input int nwin);
    win_selects = (int'(win) == idx) && (idx < nwin);
  endfunction

endpackage

// File: rtl/vagg_map_table.sv
module vagg_map_table #(
  parameter int NUM_EVT = 256,
  parameter int VIDX_W  = 3,
  parameter int BIT_W   = 6,
  localparam int EVT_W  = $clog2(NUM_EVT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_map,
  input  logic [EVT_W-1:0]  cfg_evt,
  input  logic [VIDX_W-1:0] cfg_vint,
  input  logic [BIT_W-1:0]  cfg_bit,
  input  logic [EVT_W-1:0]  lk_evt,
  output logic              lk_hit,
  output logic [VIDX_W-1:0] lk_vint,
  output logic [BIT_W-1:0]  lk_bit
);

  logic              valid_q [NUM_EVT];
  logic [VIDX_W-1:0] vint_q  [NUM_EVT];
  logic [BIT_W-1:0]  bit_q   [NUM_EVT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_EVT; i++) valid_q[i] <= 1'b0;
    end else if (cfg_valid) begin
      valid_q[cfg_evt] <= cfg_map;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_valid && cfg_map) begin
      vint_q[cfg_evt] <= cfg_vint;
      bit_q[cfg_evt]  <= cfg_bit;
    end
  end

  assign lk_hit  = valid_q[lk_evt];
  assign lk_vint = vint_q[lk_evt];
  assign lk_bit  = bit_q[lk_evt];

endmodule

// File: rtl/vagg_event_router.sv
module vagg_event_router #(
  parameter int NUM_VINT = 8,
  parameter int BITS     = 64,
  localparam int VIDX_W  = $clog2(NUM_VINT),
  localparam int BIT_W   = $clog2(BITS)
) (
  input  logic                           evt_valid,
  input  logic                           evt_up,
  input  logic                           lk_hit,
  input  logic [VIDX_W-1:0]              lk_vint,
  input  logic [BIT_W-1:0]               lk_bit,
  output logic [NUM_VINT-1:0][BITS-1:0]  up_set,
  output logic [NUM_VINT-1:0][BITS-1:0]  dn_clr
);

  logic [NUM_VINT-1:0] vsel;
  logic [BITS-1:0]     bsel;

  always_comb begin
    vsel = '0;
    bsel = '0;
    if (evt_valid && lk_hit) begin
      vsel[lk_vint] = 1'b1;
      bsel[lk_bit]  = 1'b1;
    end
  end

  for (genvar v = 0; v < NUM_VINT; v++) begin : g_route
    assign up_set[v] = (vsel[v] &&  evt_up) ? bsel : '0;
    assign dn_clr[v] = (vsel[v] && !evt_up) ? bsel : '0;
  end

endmodule

// File: rtl/vagg_vint_bank.sv
module vagg_vint_bank #(
  parameter int BITS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] en_set,
  input  logic [BITS-1:0] en_clr,
  input  logic [BITS-1:0] st_ack,
  input  logic [BITS-1:0] up_set,
  input  logic [BITS-1:0] dn_clr,
  output logic [BITS-1:0] en_q,
  output logic [BITS-1:0] st_q,
  output logic [BITS-1:0] masked,
  output logic            irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= (en_q | en_set) & ~en_clr;
      // A new up message outranks any clear landing on the same bit.
      st_q <= (st_q & ~(st_ack | dn_clr)) | up_set;
    end
  end

  assign masked = st_q & en_q;
  assign irq    = |masked;

endmodule

// File: rtl/vagg_regif.sv
module vagg_regif
  import vagg_pkg::*;
#(
  parameter int NUM_VINT = 8,
  parameter int BITS     = 64,
  parameter int ADDR_W   = 15,
  localparam int WIN_W   = ADDR_W - WIN_LG
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [BITS-1:0]               req_wdata,
  input  logic [NUM_VINT-1:0][BITS-1:0] en_q,
  input  logic [NUM_VINT-1:0][BITS-1:0] st_q,
  input  logic [NUM_VINT-1:0][BITS-1:0] masked,
  output logic [NUM_VINT-1:0][BITS-1:0] en_set,
  output logic [NUM_VINT-1:0][BITS-1:0] en_clr,
  output logic [NUM_VINT-1:0][BITS-1:0] st_ack,
  output logic                          rsp_valid,
  output logic [BITS-1:0]               rsp_rdata
);

  logic [WIN_W-1:0]  win;
  logic [WIN_LG-1:0] ofs;
  logic              wr_fire, rd_fire;
  rd_sel_e           rsel;
  logic [BITS-1:0]   rd_word;

  assign win     = req_addr[ADDR_W-1:WIN_LG];
  assign ofs     = req_addr[WIN_LG-1:0];
  assign wr_fire = req_valid &&  req_write;
  assign rd_fire = req_valid && !req_write;
  assign rsel    = decode_read(ofs);

  for (genvar v = 0; v < NUM_VINT; v++) begin : g_dec
    logic here;
    assign here      = wr_fire && win_selects((WIN_LG+8)'(win), v, NUM_VINT);
    assign en_set[v] = (here && ofs == OFS_EN_SET) ? req_wdata : '0;
    assign en_clr[v] = (here && ofs == OFS_EN_CLR) ? req_wdata : '0;
    assign st_ack[v] = (here && ofs == OFS_RAW)    ? req_wdata : '0;
  end

  always_comb begin
    rd_word = '0;
    if (int'(win) < NUM_VINT) begin
      case (rsel)
        SEL_ENABLE: rd_word = en_q[win];
        SEL_RAW:    rd_word = st_q[win];
        SEL_MASKED: rd_word = masked[win];
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/vint_aggregator.sv
module vint_aggregator #(
  parameter int NUM_VINT  = 8,
  parameter int BITS      = 64,
  parameter int NUM_EVT   = 256,
  localparam int VIDX_W   = $clog2(NUM_VINT),
  localparam int BIT_W    = $clog2(BITS),
  localparam int EVT_W    = $clog2(NUM_EVT),
  localparam int ADDR_W   = VIDX_W + 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BITS-1:0]     req_wdata,
  output logic                rsp_valid,
  output logic [BITS-1:0]     rsp_rdata,
  input  logic                cfg_valid,
  input  logic                cfg_map,
  input  logic [EVT_W-1:0]    cfg_evt,
  input  logic [VIDX_W-1:0]   cfg_vint,
  input  logic [BIT_W-1:0]    cfg_bit,
  input  logic                evt_valid,
  input  logic [EVT_W-1:0]    evt_num,
  input  logic                evt_up,
  output logic [NUM_VINT-1:0] vint_irq
);

  logic                          map_hit;
  logic [VIDX_W-1:0]             map_vint;
  logic [BIT_W-1:0]              map_bit;
  logic [NUM_VINT-1:0][BITS-1:0] up_set, dn_clr;
  logic [NUM_VINT-1:0][BITS-1:0] en_set, en_clr, st_ack;
  logic [NUM_VINT-1:0][BITS-1:0] en_q, st_q, masked;

  assign req_ready = 1'b1;

  vagg_map_table #(.NUM_EVT(NUM_EVT), .VIDX_W(VIDX_W), .BIT_W(BIT_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_map(cfg_map), .cfg_evt(cfg_evt),
    .cfg_vint(cfg_vint), .cfg_bit(cfg_bit),
    .lk_evt(evt_num), .lk_hit(map_hit), .lk_vint(map_vint), .lk_bit(map_bit)
  );

  vagg_event_router #(.NUM_VINT(NUM_VINT), .BITS(BITS)) u_route (
    .evt_valid(evt_valid), .evt_up(evt_up),
    .lk_hit(map_hit), .lk_vint(map_vint), .lk_bit(map_bit),
    .up_set(up_set), .dn_clr(dn_clr)
  );

  vagg_regif #(.NUM_VINT(NUM_VINT), .BITS(BITS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata),
    .en_q(en_q), .st_q(st_q), .masked(masked),
    .en_set(en_set), .en_clr(en_clr), .st_ack(st_ack),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  for (genvar v = 0; v < NUM_VINT; v++) begin : g_bank
    vagg_vint_bank #(.BITS(BITS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .en_set(en_set[v]), .en_clr(en_clr[v]), .st_ack(st_ack[v]),
      .up_set(up_set[v]), .dn_clr(dn_clr[v]),
      .en_q(en_q[v]), .st_q(st_q[v]), .masked(masked[v]), .irq(vint_irq[v])
    );
  end

endmodule

// File: rtl/vagg_checker.sv
module vagg_checker #(
  parameter int NUM_VINT = 8,
  parameter int BITS     = 64
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_write,
  input logic                          rsp_valid,
  input logic                          evt_valid,
  input logic                          map_hit,
  input logic [NUM_VINT-1:0][BITS-1:0] up_set,
  input logic [NUM_VINT-1:0][BITS-1:0] dn_clr,
  input logic [NUM_VINT-1:0][BITS-1:0] st_q,
  input logic [NUM_VINT-1:0]           vint_irq
);

  assert_rd_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_stray_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // Covers R10 too: the set lands even when an acknowledge hits the same bit.
  assert_up_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|up_set) |=> ((st_q & $past(up_set)) == $past(up_set)));

  assert_down_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_clr) |=> ((st_q & $past(dn_clr)) == '0));

  assert_drop_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !map_hit && !(req_valid && req_write)) |=> $stable(st_q));

  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_set, dn_clr}));

  for (genvar v = 0; v < NUM_VINT; v++) begin : g_irq
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vint_irq[v]) |-> $past((|up_set[v]) || (req_valid && req_write)));
  end

endmodule

bind vint_aggregator vagg_checker #(.NUM_VINT(NUM_VINT), .BITS(BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .evt_valid(evt_valid), .map_hit(map_hit),
  .up_set(up_set), .dn_clr(dn_clr), .st_q(st_q), .vint_irq(vint_irq)
);

// File: tb/sim_vint_aggregator.sv
`timescale 1ns/1ps
module sim_vint_aggregator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0;
  logic        req_ready;
  logic [14:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        cfg_valid = 0, cfg_map = 0;
  logic [7:0]  cfg_evt = '0;
  logic [2:0]  cfg_vint = '0;
  logic [5:0]  cfg_bit = '0;
  logic        evt_valid = 0, evt_up = 0;
  logic [7:0]  evt_num = '0;
  logic [7:0]  vint_irq;

  always #10 clk = ~clk;

  vint_aggregator u0 (.*);

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [63:0] en_m [8];
  logic [63:0] st_m [8];
  bit          mv_ok [256];
  int          mv_v [256];
  int          mv_b [256];

  logic [63:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [14:0] reg_addr(input int v, input int ofs);
    return 15'(v * 4096 + ofs);
  endfunction

  function automatic logic [63:0] model_read(input int v, input int ofs);
    if (ofs == 'h0 || ofs == 'h8) return en_m[v];
    if (ofs == 'h18) return st_m[v];
    if (ofs == 'h20) return st_m[v] & en_m[v];
    return '0;
  endfunction

  function automatic logic [7:0] model_irq();
    logic [7:0] r;
    for (int v = 0; v < 8; v++) r[v] = |(st_m[v] & en_m[v]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !finished) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected response", 64'(rsp_valid), 64'd0);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input int v, input int ofs, input logic [63:0] d);
    req_valid = 1; req_write = 1; req_addr = reg_addr(v, ofs); req_wdata = d;
    if (ofs == 'h0)  en_m[v] = en_m[v] | d;
    if (ofs == 'h8)  en_m[v] = en_m[v] & ~d;
    if (ofs == 'h18) st_m[v] = st_m[v] & ~d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int v, input int ofs, input string tag);
    exp_q.push_back(model_read(v, ofs));
    tag_q.push_back(tag);
    req_valid = 1; req_write = 0; req_addr = reg_addr(v, ofs);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic cfg(input int e, input bit m, input int v, input int b);
    cfg_valid = 1; cfg_map = m; cfg_evt = 8'(e); cfg_vint = 3'(v); cfg_bit = 6'(b);
    mv_ok[e] = m;
    if (m) begin mv_v[e] = v; mv_b[e] = b; end
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic apply_evt(input int e, input bit up);
    if (mv_ok[e]) begin
      if (up) st_m[mv_v[e]][mv_b[e]] = 1'b1;
      else    st_m[mv_v[e]][mv_b[e]] = 1'b0;
    end
  endtask

  task automatic ev(input int e, input bit up);
    evt_valid = 1; evt_num = 8'(e); evt_up = up;
    apply_evt(e, up);
    @(negedge clk);
    evt_valid = 0;
  endtask

  // up message and software pending clear in the same cycle
  task automatic ev_with_ack(input int e, input int v, input logic [63:0] ack);
    evt_valid = 1; evt_num = 8'(e); evt_up = 1;
    req_valid = 1; req_write = 1; req_addr = reg_addr(v, 'h18); req_wdata = ack;
    st_m[v] = st_m[v] & ~ack;
    apply_evt(e, 1'b1);
    @(negedge clk);
    evt_valid = 0; req_valid = 0; req_write = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin en_m[i] = '0; st_m[i] = '0; end
    for (int i = 0; i < 256; i++) begin mv_ok[i] = 0; mv_v[i] = 0; mv_b[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq after reset", 64'(vint_irq), 64'd0);
    check("R12 ready", 64'(req_ready), 64'd1);
    rd(0, 'h0, "R1 enable v0");
    rd(7, 'h18, "R1 raw v7");
    ev(5, 1);                            // R1/R9: table invalid, dropped
    rd(2, 'h18, "R1 unmapped after reset v2");
    rd(0, 'h18, "R9 unmapped after reset v0");

    cfg(5, 1, 2, 7);
    cfg(200, 1, 7, 63);
    cfg(0, 1, 0, 0);

    // R2: enable set, zero bits keep value
    wr(2, 'h0, 64'hC);
    wr(2, 'h0, 64'h1);
    rd(2, 'h0, "R2 enable accumulate");
    wr(2, 'h0, 64'h80);
    rd(2, 'h8, "R5 enable via clear offset");

    // R4/R5/R6
    ev(5, 1);
    check("R6 irq after up", 64'(vint_irq), 64'(model_irq()));
    rd(2, 'h18, "R4 raw pending");
    rd(2, 'h20, "R5 masked");

    // R3: mask keeps pending
    wr(2, 'h8, 64'h80);
    check("R3 irq after mask", 64'(vint_irq), 64'd0);
    rd(2, 'h20, "R3 masked after clear");
    rd(2, 'h18, "R3 raw kept");
    wr(2, 'h0, 64'h80);
    check("R6 irq after unmask", 64'(vint_irq), 64'h04);

    // R7: acknowledge clears only the written bit
    ev(0, 1);
    wr(0, 'h18, 64'h2);
    rd(0, 'h18, "R7 other bit kept");
    wr(2, 'h18, 64'h80);
    check("R7 irq after ack", 64'(vint_irq), 64'd0);
    rd(2, 'h18, "R7 raw after ack");

    // R13/R8: top window, level source
    ev(200, 1);
    check("R6 pending not enabled", 64'(vint_irq), 64'd0);
    rd(7, 'h18, "R13 window 7 bit 63");
    wr(7, 'h0, 64'h8000_0000_0000_0000);
    check("R6 irq v7", 64'(vint_irq), 64'h80);
    wr(7, 'h18, 64'h0);
    check("R7 zero ack no effect", 64'(vint_irq), 64'h80);
    ev(200, 0);
    check("R8 irq after down", 64'(vint_irq), 64'd0);
    rd(7, 'h18, "R8 raw after down");

    // R10: up beats same-cycle acknowledge
    ev(5, 1);
    ev_with_ack(5, 2, 64'h80);
    rd(2, 'h18, "R10 up wins");
    check("R10 irq", 64'(vint_irq), 64'h04);

    // R11: undefined offsets
    wr(2, 'h10, '1);
    wr(2, 'h28, '1);
    rd(2, 'h0, "R11 enable untouched");
    rd(2, 'h18, "R11 raw untouched");
    rd(2, 'h10, "R11 read hole");
    rd(2, 'h800, "R11 read far offset");

    // R9: unprogram, then down is dropped
    cfg(5, 0, 0, 0);
    ev(5, 0);
    rd(2, 'h18, "R9 removed entry dropped");
    cfg(5, 1, 3, 0);
    ev(5, 1);
    rd(3, 'h18, "R9 remapped target");
    rd(2, 'h18, "R9 old target untouched");

    // R12: back-to-back reads stay ordered
    rd(3, 'h18, "R12 b2b first");
    rd(2, 'h0, "R12 b2b second");
    repeat (3) @(negedge clk);
    check("R12 all responses", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule